// File: doc/BRIEF.md
# Slave-Port Programming Interface for an On-Chip Nonvolatile Word Array

This block lets an external programmer write words into an on-chip nonvolatile array and read them back over a shared command/address/data bus. The programmer works through a few handshake lines. A falling edge on the active-low latch strobe hands over an address and a command. A low pulse on the active-low program strobe carries out one operation. An active-low step input makes each operation move on to the next word without a new address phase.

In program mode, the data on the bus is captured when the program strobe falls. The word is written when the strobe rises. It is then read back and compared, which drives a per-word pass flag and a sticky all-pass flag. In dump mode, the addressed word is driven onto the output bus and held there. The array is a synchronous memory that resets to the erased value (all ones). It has a fault input that corrupts the stored word, so failed writes can be produced on purpose.

Top module: `nvm_slave_prog`

## Requirements
- R1: After reset, `word_ok` is 0, `all_ok` is 1, `bus_oe` is 0, `bus_out` is 0, the captured mode is dump and the captured word address is 0. Every array word holds 16'hFFFF.
- R2: Strobe edges are ignored until `STARTUP_CYCLES` clock cycles (default 1100) have passed after reset is released.
- R3: A falling edge on `latch_n` captures the mode from `bus_in[0]` (1 = program, 0 = dump) and the word address from `bus_in[ADDR_W:1]`.
- R4: In program mode, a falling edge on `prog_n` captures `bus_in` as write data. The next rising edge of `prog_n` writes that word into the array at the captured address.
- R5: `word_ok` reads the compare result of the last program operation no later than 3 cycles after the rising edge of `prog_n`: 1 if the read-back equals the written data, otherwise 0. A falling edge of `prog_n` or of `latch_n` clears it. In dump mode it is never set.
- R6: `all_ok` falls on the first failed compare and stays 0 through later passing words. Only reset or a rising edge of `pgm_mode` sets it back to 1.
- R7: In dump mode, within one cycle of a falling edge on `prog_n`, `bus_out` carries the addressed word and `bus_oe` is 1. The value is held until the next accepted latch falling edge, which drops `bus_oe` within one cycle.
- R8: When `step_n` is low, every completed operation advances the word address by one, so the next operation needs no latch phase. When `step_n` is high, the address is unchanged.
- R9: When `fault_inject` is 1 at the write, the stored word has bit 0 inverted.
- R10: While `pgm_mode` is 0, all latch and program strobe edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pgm_mode | input | 1 | Programming mode enable; a rising edge re-arms `all_ok` |
| latch_n | input | 1 | Active-low address/command latch strobe |
| prog_n | input | 1 | Active-low program/dump pulse |
| step_n | input | 1 | Active-low address auto-advance |
| fault_inject | input | 1 | Corrupts bit 0 of words written while high |
| bus_in | input | DATA_W | Command, address and write data from the programmer |
| bus_out | output | DATA_W | Dumped word |
| bus_oe | output | 1 | High while `bus_out` carries a dumped word |
| word_ok | output | 1 | Pass flag of the last programmed word |
| all_ok | output | 1 | Sticky pass flag across all programmed words |

## Verification
A wrong captured address shows up at the next dump: `bus_out` carries a neighbouring or erased word one cycle after the program strobe falls. A wrong step count shows up in the same way, one word off. A wrong mode bit shows up immediately, as `bus_oe` rising during what should be a write. A broken write or compare path shows up at `word_ok` within three cycles of the strobe rising. A sticky flag that clears too early shows up as `all_ok` returning high on a later passing word, long before any re-entry into programming mode.

// File: rtl/nvm_prog_pkg.sv
`timescale 1ns/1ps
package nvm_prog_pkg;

    typedef enum logic {
        OP_DUMP    = 1'b0,
        OP_PROGRAM = 1'b1
    } op_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETTLE = 2'd1,
        SQ_CHECK  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic latch_fall;
        logic prog_fall;
        logic prog_rise;
        logic mode_rise;
    } strobe_ev_t;

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/edge_tracker.sv
`timescale 1ns/1ps
module edge_tracker #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_in,
    output logic [N-1:0] sig_prev
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) sig_prev[g] <= RST_VAL[g];
            else     sig_prev[g] <= sig_in[g];
        end
    end
endmodule

// File: rtl/nvm_array_model.sv
`timescale 1ns/1ps
module nvm_array_model #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fail_inject,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] stored_word;

    // A forced failure flips the lowest bit of what lands in the cell.
    assign stored_word = wr_data ^ {{(DATA_W-1){1'b0}}, fail_inject};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
            rd_data <= '1;
        end else begin
            if (wr_en) cells[addr] <= stored_word;
            rd_data <= cells[addr];
        end
    end
endmodule

// File: rtl/prog_sequencer.sv
`timescale 1ns/1ps
module prog_sequencer
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int DATA_W         = 16,
    parameter int STARTUP_CYCLES = 1100
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_ev_t        ev,
    input  logic              pgm_mode,
    input  logic              step_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              word_ok,
    output logic              all_ok
);
    localparam int CNT_W = cnt_width(STARTUP_CYCLES);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STARTUP_CYCLES);

    logic [CNT_W-1:0] warm_cnt;
    op_mode_e         mode_q;
    seq_state_e       state_q;
    logic             op_open_q;
    logic             live, take_latch, take_fall, take_rise, match;

    assign live       = (warm_cnt == CNT_MAX) && pgm_mode;
    assign take_latch = ev.latch_fall && live && (state_q == SQ_IDLE);
    assign take_fall  = ev.prog_fall  && live && (state_q == SQ_IDLE) && !op_open_q;
    assign take_rise  = ev.prog_rise  && live && (state_q == SQ_IDLE) && op_open_q;
    assign wr_en      = take_rise && (mode_q == OP_PROGRAM);
    assign match      = (rd_data == data_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_cnt  <= '0;
            mode_q    <= OP_DUMP;
            state_q   <= SQ_IDLE;
            op_open_q <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            bus_out   <= '0;
            bus_oe    <= 1'b0;
            word_ok   <= 1'b0;
            all_ok    <= 1'b1;
        end else begin
            if (warm_cnt != CNT_MAX) warm_cnt <= warm_cnt + 1'b1;

            if (ev.mode_rise) begin
                all_ok  <= 1'b1;
                word_ok <= 1'b0;
            end

            if (take_latch) begin
                addr_q  <= bus_in[ADDR_W:1];
                mode_q  <= op_mode_e'(bus_in[0]);
                bus_oe  <= 1'b0;
                word_ok <= 1'b0;
            end

            if (take_fall) begin
                op_open_q <= 1'b1;
                word_ok   <= 1'b0;
                if (mode_q == OP_PROGRAM) begin
                    data_q <= bus_in;
                end else begin
                    bus_out <= rd_data;
                    bus_oe  <= 1'b1;
                end
            end

            if (take_rise) begin
                op_open_q <= 1'b0;
                if (mode_q == OP_PROGRAM) state_q <= SQ_SETTLE;
                else if (!step_n)         addr_q  <= addr_q + 1'b1;
            end

            case (state_q)
                SQ_SETTLE: state_q <= SQ_CHECK;
                SQ_CHECK: begin
                    word_ok <= match;
                    all_ok  <= all_ok && match;
                    if (!step_n) addr_q <= addr_q + 1'b1;
                    state_q <= SQ_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nvm_slave_prog.sv
`timescale 1ns/1ps
module nvm_slave_prog
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W         = 6,
    parameter int DATA_W         = 16,
    parameter int STARTUP_CYCLES = 1100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_mode,
    input  logic              latch_n,
    input  logic              prog_n,
    input  logic              step_n,
    input  logic              fault_inject,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              word_ok,
    output logic              all_ok
);
    logic [2:0]        prev;
    strobe_ev_t        ev;
    logic              wr_en;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rd_data;

    // bit 2: mode enable (rests low), bits 1..0: active-low strobes (rest high)
    edge_tracker #(.N(3), .RST_VAL(3'b011)) i_edges (
        .clk     (clk),
        .rst     (rst),
        .sig_in  ({pgm_mode, latch_n, prog_n}),
        .sig_prev(prev)
    );

    assign ev.latch_fall = prev[1] && !latch_n;
    assign ev.prog_fall  = prev[0] && !prog_n;
    assign ev.prog_rise  = !prev[0] && prog_n;
    assign ev.mode_rise  = !prev[2] && pgm_mode;

    prog_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STARTUP_CYCLES(STARTUP_CYCLES)
    ) i_seq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .pgm_mode(pgm_mode),
        .step_n  (step_n),
        .bus_in  (bus_in),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .bus_out (bus_out),
        .bus_oe  (bus_oe),
        .word_ok (word_ok),
        .all_ok  (all_ok)
    );

    nvm_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr_q),
        .wr_data    (data_q),
        .fail_inject(fault_inject),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/nvm_slave_prog_chk.sv
`timescale 1ns/1ps
module nvm_slave_prog_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              pgm_mode,
    input logic              latch_n,
    input logic              prog_n,
    input logic [DATA_W-1:0] bus_out,
    input logic              bus_oe,
    input logic              word_ok,
    input logic              all_ok
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (all_ok && !word_ok && !bus_oe));

    p_sticky_fail_r6: assert property (@(posedge clk) disable iff (rst)
        (!all_ok && !(pgm_mode && !$past(pgm_mode))) |=> !all_ok);

    p_oe_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (pgm_mode && $past(latch_n) && !latch_n) |=> !bus_oe);

    p_dump_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe) && !($past(prog_n, 2) && !$past(prog_n)))
        |-> $stable(bus_out));

    p_pass_not_in_dump_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(word_ok) |-> !bus_oe);
endmodule

bind nvm_slave_prog nvm_slave_prog_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .pgm_mode(pgm_mode),
    .latch_n (latch_n),
    .prog_n  (prog_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .word_ok (word_ok),
    .all_ok  (all_ok)
);

// File: tb/test_nvm_slave_prog.sv
`timescale 1ns/1ps
module test_nvm_slave_prog;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int NVEC   = 6;
    // {fault, address, data}
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b0, 6'd3,  16'hA5A5},
        {1'b0, 6'd10, 16'h1234},
        {1'b0, 6'd63, 16'hFFFE},
        {1'b1, 6'd20, 16'h0F0F},
        {1'b0, 6'd21, 16'h8001},
        {1'b0, 6'd0,  16'h0000}
    };

    logic clk = 0, rst = 1, pgm_mode = 1, latch_n = 1, prog_n = 1, step_n = 1, fault_inject = 0;
    logic [DATA_W-1:0] bus_in = '0, bus_out;
    logic bus_oe, word_ok, all_ok;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [DATA_W-1:0] shadow [64];
    bit any_fail;

    always #2.5 clk = ~clk;

    nvm_slave_prog i_nvm_slave_prog (
        .clk(clk), .rst(rst), .pgm_mode(pgm_mode), .latch_n(latch_n), .prog_n(prog_n),
        .step_n(step_n), .fault_inject(fault_inject), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .word_ok(word_ok), .all_ok(all_ok)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic latch_cmd(input logic [ADDR_W-1:0] a, input logic prog_mode);
        bus_in  = DATA_W'({a, prog_mode});
        latch_n = 0; tick(3);
        latch_n = 1; tick(2);
    endtask

    task automatic prog_low(input logic [DATA_W-1:0] d);
        bus_in = d;
        prog_n = 0; tick(3);
    endtask

    task automatic prog_high;
        prog_n = 1; tick(5);
    endtask

    task automatic dump_expect(input string req, input logic [DATA_W-1:0] exp);
        prog_low(16'h0000);
        chk(req, bus_out, exp);
        chk(req, DATA_W'(bus_oe), 16'd1);
        prog_high();
    endtask

    initial begin
        for (int i = 0; i < 64; i++) shadow[i] = 16'hFFFF;
        any_fail = 0;
        tick(3);
        rst = 0;
        chk("R1 word_ok", DATA_W'(word_ok), 0);
        chk("R1 all_ok", DATA_W'(all_ok), 1);
        chk("R1 bus_oe", DATA_W'(bus_oe), 0);
        chk("R1 bus_out", bus_out, 0);

        // R2: program-mode latch during warm-up is dropped; mode stays dump
        latch_cmd(6'd5, 1'b1);
        tick(1150);
        prog_low(16'h1111);
        chk("R2 early latch ignored (dump mode kept)", DATA_W'(bus_oe), 16'd1);
        chk("R2/R1 erased word at address 0", bus_out, 16'hFFFF);
        prog_high();
        latch_cmd(6'd5, 1'b0);
        dump_expect("R2 no write happened at 5", 16'hFFFF);

        // R3/R4/R5/R6/R9: table walk in program mode
        for (int i = 0; i < NVEC; i++) begin
            logic f;
            logic [ADDR_W-1:0] a;
            logic [DATA_W-1:0] d;
            {f, a, d} = VEC[i];
            fault_inject = f;
            latch_cmd(a, 1'b1);
            prog_low(d);
            chk("R5 word_ok cleared by prog fall", DATA_W'(word_ok), 0);
            prog_high();
            fault_inject = 0;
            shadow[a] = d ^ {15'b0, f};
            if (f) any_fail = 1;
            chk("R5 word_ok after write", DATA_W'(word_ok), DATA_W'(!f));
            chk("R6 all_ok sticky", DATA_W'(all_ok), DATA_W'(!any_fail));
        end

        // R8: stepping program of three words from address 40
        latch_cmd(6'd40, 1'b1);
        step_n = 0;
        for (int k = 0; k < 3; k++) begin
            prog_low(DATA_W'(16'h1111 * (k + 1)));
            prog_high();
            shadow[40 + k] = DATA_W'(16'h1111 * (k + 1));
            chk("R8 stepped write passes", DATA_W'(word_ok), 16'd1);
        end
        step_n = 1;
        latch_cmd(6'd40, 1'b0);
        step_n = 0;
        for (int k = 0; k < 3; k++)
            dump_expect("R8 stepped dump", shadow[40 + k]);
        step_n = 1;
        dump_expect("R8 no step holds address 43", shadow[43]);
        dump_expect("R8 no step holds address 43 again", shadow[43]);

        // R3/R7/R9: readback of table, including corrupted word
        for (int i = 0; i < NVEC; i++) begin
            logic [ADDR_W-1:0] a;
            a = VEC[i][21:16];
            latch_cmd(a, 1'b0);
            chk("R7 bus_oe dropped by latch", DATA_W'(bus_oe), 0);
            dump_expect("R3/R9 readback", shadow[a]);
        end
        tick(10);
        chk("R7 dump held", bus_out, shadow[0]);
        chk("R7 oe held", DATA_W'(bus_oe), 1);

        // R10: strobes ignored with programming mode off
        pgm_mode = 0; tick(2);
        latch_cmd(6'd3, 1'b1);
        prog_low(16'h0000);
        prog_high();
        chk("R10 latch ignored, oe kept", DATA_W'(bus_oe), 1);
        chk("R10 bus_out kept", bus_out, shadow[0]);
        chk("R6 all_ok still low", DATA_W'(all_ok), 0);
        pgm_mode = 1; tick(3);
        chk("R6 all_ok re-armed by mode entry", DATA_W'(all_ok), 1);
        latch_cmd(6'd3, 1'b0);
        chk("R7 oe dropped", DATA_W'(bus_oe), 0);
        dump_expect("R10 word 3 untouched", 16'hA5A5);
        chk("R5 no pass flag in dump", DATA_W'(word_ok), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule